// File: doc/BRIEF.md
# Masked Slave Address Matcher

This block decides whether a two-wire bus target has been addressed. A bit-level front end, which is not part of this block, captures each byte and presents it with a one-cycle strobe. It also flags every start and repeated start. The matcher looks only at the address phase that follows a start. That phase is one byte in 7-bit mode and two bytes in 10-bit mode. The matcher compares the phase against a programmed 10-bit own address. Any address bit whose mask bit is 1 is treated as a don't-care.

The general call address can be recognised as well, when it is enabled. It is a first byte of 0x00, which is write direction. This match ignores the own address and the mask. A successful match produces a one-cycle pulse. It also updates a type flag that tells an own-address hit from a general call. An inhibit input suppresses every match, so that the target stays silent on the bus.

Top module: `slv_addr_match`

## Requirements
- R1: After reset, `match_o` and `gcall_flag` are 0, and a byte strobe that comes before any start produces no match.
- R2: Only the address phase directly after a start is examined. Further byte strobes produce no match until a new start arrives.
- R3: In 7-bit mode (`mode_10b`=0), byte bits 7:1 are compared with `own_addr[6:0]`. Byte bit 0 (R/W) and `own_addr[9:7]` are ignored. On a hit, `match_o` is 1 for exactly one cycle, the cycle after the clock edge that samples the byte strobe.
- R4: A 1 in `addr_mask[i]` makes address bit i a don't-care. This holds in both modes.
- R5: When `gc_en`=1, a first byte of 0x00 matches whatever `own_addr` and `addr_mask` hold. The match sets `gcall_flag` to 1. A first byte of 0x01 is not a general call. When `gc_en`=0, 0x00 is treated only as an ordinary address.
- R6: When a first byte qualifies both as a general call and as an own-address match, the general call wins and `gcall_flag` becomes 1.
- R7: In 10-bit mode, the first byte must be 11110 followed by `own_addr[9:8]` (masked) in bits 2:1. Bit 0 is ignored. The second byte must equal `own_addr[7:0]` (masked). `match_o` can pulse only after the second byte.
- R8: A start clears any pending partial 10-bit match. A byte strobe in the same cycle as a start is ignored, and the next strobe is treated as the first address byte.
- R9: While `slave_inhibit`=1 at the clock edge that samples a byte, that byte produces no match. If it was the first byte of a 10-bit phase, no match follows it either.
- R10: `gcall_flag` is 0 after an own-address match and 1 after a general call match. It keeps its value until the next match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_det | input | 1 | One-cycle strobe for a start or repeated start |
| byte_vld | input | 1 | One-cycle strobe marking `byte_data` as valid |
| byte_data | input | 8 | Received byte, MSB first on the wire |
| own_addr | input | 10 | Programmed own address |
| addr_mask | input | 10 | Don't-care mask, 1 = ignore bit |
| mode_10b | input | 1 | 1 = 10-bit addressing, 0 = 7-bit |
| gc_en | input | 1 | Enable general call recognition |
| slave_inhibit | input | 1 | Suppress all matches |
| match_o | output | 1 | One-cycle match pulse |
| gcall_flag | output | 1 | Type of the last match: 1 general call, 0 own address |

## Verification
Some properties are checked by assertions on every cycle. A match pulse never lasts two cycles. No pulse follows an inhibited byte or a strobe that coincided with a start. A general call flag is always backed by a 0x00 byte with the enable set. An own-address pulse always agrees with the masked comparison of the byte that caused it. The type flag moves only together with a pulse.

Other behaviour depends on the history of several bytes, so only the bench scenarios can show it. This covers the two-byte 10-bit sequence, including a wrong tag and a wrong low byte. It also covers a start that cancels a half-finished 10-bit match, a single match per start, and general call precedence.

// File: rtl/slv_am_pkg.sv
package slv_am_pkg;
  localparam int ADDR_W   = 10;
  localparam int BYTE_W   = 8;
  localparam int A7_W     = 7;
  localparam int HI_W     = ADDR_W - BYTE_W;
  localparam int TAG_W    = BYTE_W - HI_W - 1;
  localparam logic [TAG_W-1:0]  TEN_BIT_TAG = 5'b11110;
  localparam logic [BYTE_W-1:0] GC_BYTE     = '0;

  typedef enum logic [1:0] {
    AM_IDLE   = 2'd0,
    AM_FIRST  = 2'd1,
    AM_SECOND = 2'd2
  } am_state_e;
endpackage

// File: rtl/am_rst_sync.sv
module am_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/am_masked_cmp.sv
module am_masked_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  logic [W-1:0] dont_care,
  output logic         equal
);
  logic [W-1:0] bit_ok;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_ok[i] = dont_care[i] | (lhs[i] ~^ rhs[i]);
  end

  assign equal = &bit_ok;
endmodule

// File: rtl/am_seq.sv
module am_seq
  import slv_am_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_det,
  input  logic byte_vld,
  input  logic inhibit,
  input  logic mode_10b,
  input  logic gc_hit,
  input  logic short_hit,
  input  logic tag_hit,
  input  logic low_hit,
  output logic hit,
  output logic hit_gc
);
  am_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    hit     = 1'b0;
    hit_gc  = 1'b0;
    if (start_det) begin
      state_d = AM_FIRST;
    end else if (byte_vld) begin
      state_d = AM_IDLE;
      unique case (state_q)
        AM_FIRST: begin
          if (!inhibit) begin
            if (gc_hit) begin
              hit    = 1'b1;
              hit_gc = 1'b1;
            end else if (!mode_10b) begin
              hit = short_hit;
            end else if (tag_hit) begin
              state_d = AM_SECOND;
            end
          end
        end
        AM_SECOND: hit = !inhibit && low_hit;
        default:   hit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= AM_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/am_out_reg.sv
module am_out_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic hit_gc,
  output logic match_q,
  output logic gc_q
);
  logic gc_en_ld;

  assign gc_en_ld = hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gc_q <= 1'b0;
    else if (gc_en_ld) gc_q <= hit_gc;
  end
endmodule

// File: rtl/slv_addr_match.sv
module slv_addr_match
  import slv_am_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_det,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [ADDR_W-1:0] addr_mask,
  input  logic              mode_10b,
  input  logic              gc_en,
  input  logic              slave_inhibit,
  output logic              match_o,
  output logic              gcall_flag
);
  logic rst_int_n;
  logic short_hit, hi_hit, low_hit, tag_hit, gc_hit;
  logic hit, hit_gc;

  am_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  // 7-bit address sits in byte bits 7:1
  am_masked_cmp #(.W(A7_W)) u_cmp7 (
    .lhs(byte_data[BYTE_W-1:1]), .rhs(own_addr[A7_W-1:0]),
    .dont_care(addr_mask[A7_W-1:0]), .equal(short_hit)
  );

  // 10-bit upper address bits sit in byte bits 2:1 of the first byte
  am_masked_cmp #(.W(HI_W)) u_cmp_hi (
    .lhs(byte_data[HI_W:1]), .rhs(own_addr[ADDR_W-1:BYTE_W]),
    .dont_care(addr_mask[ADDR_W-1:BYTE_W]), .equal(hi_hit)
  );

  am_masked_cmp #(.W(BYTE_W)) u_cmp_lo (
    .lhs(byte_data), .rhs(own_addr[BYTE_W-1:0]),
    .dont_care(addr_mask[BYTE_W-1:0]), .equal(low_hit)
  );

  assign tag_hit = (byte_data[BYTE_W-1:HI_W+1] == TEN_BIT_TAG) && hi_hit;
  assign gc_hit  = gc_en && (byte_data == GC_BYTE);

  am_seq u_seq (
    .clk(clk), .rst_n(rst_int_n), .start_det(start_det), .byte_vld(byte_vld),
    .inhibit(slave_inhibit), .mode_10b(mode_10b), .gc_hit(gc_hit),
    .short_hit(short_hit), .tag_hit(tag_hit), .low_hit(low_hit),
    .hit(hit), .hit_gc(hit_gc)
  );

  am_out_reg u_out (
    .clk(clk), .rst_n(rst_int_n), .hit(hit), .hit_gc(hit_gc),
    .match_q(match_o), .gc_q(gcall_flag)
  );
endmodule

// File: rtl/slv_addr_match_chk.sv
module slv_addr_match_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_det,
  input logic       byte_vld,
  input logic [7:0] byte_data,
  input logic [9:0] own_addr,
  input logic [9:0] addr_mask,
  input logic       mode_10b,
  input logic       gc_en,
  input logic       slave_inhibit,
  input logic       match_o,
  input logic       gcall_flag
);
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |=> !match_o);

  assert_inhibit_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    slave_inhibit |=> !match_o);

  assert_needs_clean_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> ($past(byte_vld) && !$past(start_det)));

  assert_gc_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o && gcall_flag) |-> ($past(gc_en) && ($past(byte_data) == 8'h00)));

  assert_gc_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o && !gcall_flag && !$past(mode_10b)) |->
      !($past(gc_en) && ($past(byte_data) == 8'h00)));

  assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !match_o |-> $stable(gcall_flag));

  assert_own7_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o && !gcall_flag && !$past(mode_10b)) |->
      ((($past(byte_data[7:1]) ^ $past(own_addr[6:0])) & ~$past(addr_mask[6:0])) == 7'd0));

  assert_own10_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o && !gcall_flag && $past(mode_10b)) |->
      ((($past(byte_data) ^ $past(own_addr[7:0])) & ~$past(addr_mask[7:0])) == 8'd0));
endmodule

bind slv_addr_match slv_addr_match_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_det(start_det), .byte_vld(byte_vld),
  .byte_data(byte_data), .own_addr(own_addr), .addr_mask(addr_mask),
  .mode_10b(mode_10b), .gc_en(gc_en), .slave_inhibit(slave_inhibit),
  .match_o(match_o), .gcall_flag(gcall_flag)
);

// File: tb/slv_addr_match_tb.sv
module slv_addr_match_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_det = 1'b0;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic [9:0] own_addr = 10'h000;
  logic [9:0] addr_mask = 10'h000;
  logic       mode_10b = 1'b0;
  logic       gc_en = 1'b0;
  logic       slave_inhibit = 1'b0;
  logic       match_o, gcall_flag;

  int    checks = 0;
  int    failures = 0;
  string cur_tag = "R1";
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;

  // behavioural reference: phase 0 idle, 1 expecting first byte, 2 expecting second
  int phase = 0;
  bit exp_m = 1'b0;
  bit exp_g = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slv_addr_match u_dut (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .byte_vld(byte_vld),
    .byte_data(byte_data), .own_addr(own_addr), .addr_mask(addr_mask),
    .mode_10b(mode_10b), .gc_en(gc_en), .slave_inhibit(slave_inhibit),
    .match_o(match_o), .gcall_flag(gcall_flag)
  );

  function automatic bit eq_bits(int a, int b, int m, int w);
    int keep = ((1 << w) - 1) & ~m;
    return ((a ^ b) & keep) == 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      phase <= 0; exp_m <= 1'b0; exp_g <= 1'b0;
    end else begin
      exp_m <= 1'b0;
      if (start_det) phase <= 1;
      else if (byte_vld) begin
        phase <= 0;
        if (phase == 1 && !slave_inhibit) begin
          if (gc_en && byte_data == 8'h00) begin
            exp_m <= 1'b1; exp_g <= 1'b1;
          end else if (!mode_10b) begin
            if (eq_bits(int'(byte_data) >> 1, int'(own_addr), int'(addr_mask), 7)) begin
              exp_m <= 1'b1; exp_g <= 1'b0;
            end
          end else if ((int'(byte_data) >> 3) == 30 &&
                       eq_bits((int'(byte_data) >> 1), int'(own_addr) >> 8,
                               int'(addr_mask) >> 8, 2)) begin
            phase <= 2;
          end
        end else if (phase == 2 && !slave_inhibit &&
                     eq_bits(int'(byte_data), int'(own_addr), int'(addr_mask), 8)) begin
          exp_m <= 1'b1; exp_g <= 1'b0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      checks++;
      if (match_o !== exp_m || gcall_flag !== exp_g) begin
        failures++;
        $display("FAIL %s model compare: match_o=%0b gcall_flag=%0b expected %0b %0b",
                 cur_tag, match_o, gcall_flag, exp_m, exp_g);
      end
    end
  end

  task automatic check_out(bit em, bit eg, string tag);
    checks++;
    if (match_o !== em || gcall_flag !== eg) begin
      failures++;
      $display("FAIL %s directed: match_o=%0b gcall_flag=%0b expected %0b %0b",
               tag, match_o, gcall_flag, em, eg);
    end
  endtask

  task automatic do_start();
    @(negedge clk); start_det = 1'b1;
    @(negedge clk); start_det = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] b);
    @(negedge clk); byte_vld = 1'b1; byte_data = b;
    @(negedge clk); byte_vld = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    report();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    cmp_on = 1'b1;
    cur_tag = "R1";
    check_out(1'b0, 1'b0, "R1");
    own_addr = 10'h2A5;
    send_byte(8'h4A);
    check_out(1'b0, 1'b0, "R1");

    cur_tag = "R3";
    do_start(); send_byte(8'h4A); check_out(1'b1, 1'b0, "R3");
    @(negedge clk); check_out(1'b0, 1'b0, "R3");
    do_start(); send_byte(8'h4B); check_out(1'b1, 1'b0, "R3");
    do_start(); send_byte(8'h4C); check_out(1'b0, 1'b0, "R3");
    own_addr = 10'h3A5;
    do_start(); send_byte(8'h4A); check_out(1'b1, 1'b0, "R3");

    cur_tag = "R4";
    own_addr = 10'h2A5; addr_mask = 10'h003;
    do_start(); send_byte(8'h4C); check_out(1'b1, 1'b0, "R4");
    do_start(); send_byte(8'h42); check_out(1'b0, 1'b0, "R4");
    addr_mask = 10'h000;

    cur_tag = "R2";
    do_start(); send_byte(8'h4A); check_out(1'b1, 1'b0, "R2");
    send_byte(8'h4A); check_out(1'b0, 1'b0, "R2");

    cur_tag = "R5";
    gc_en = 1'b1;
    do_start(); send_byte(8'h00); check_out(1'b1, 1'b1, "R5");
    cur_tag = "R10";
    idle(5); check_out(1'b0, 1'b1, "R10");
    cur_tag = "R5";
    do_start(); send_byte(8'h01); check_out(1'b0, 1'b1, "R5");
    gc_en = 1'b0;
    do_start(); send_byte(8'h00); check_out(1'b0, 1'b1, "R5");
    cur_tag = "R10";
    do_start(); send_byte(8'h4A); check_out(1'b1, 1'b0, "R10");

    cur_tag = "R6";
    own_addr = 10'h000; gc_en = 1'b1;
    do_start(); send_byte(8'h00); check_out(1'b1, 1'b1, "R6");
    gc_en = 1'b0;
    do_start(); send_byte(8'h00); check_out(1'b1, 1'b0, "R6");

    cur_tag = "R7";
    own_addr = 10'h2A5; mode_10b = 1'b1;
    do_start(); send_byte(8'hF4); check_out(1'b0, 1'b0, "R7");
    send_byte(8'hA5); check_out(1'b1, 1'b0, "R7");
    do_start(); send_byte(8'hE4); send_byte(8'hA5); check_out(1'b0, 1'b0, "R7");
    do_start(); send_byte(8'hF4); send_byte(8'hA6); check_out(1'b0, 1'b0, "R7");
    do_start(); send_byte(8'hF5); send_byte(8'hA5); check_out(1'b1, 1'b0, "R7");
    cur_tag = "R4";
    addr_mask = 10'h100;
    do_start(); send_byte(8'hF6); send_byte(8'hA5); check_out(1'b1, 1'b0, "R4");
    addr_mask = 10'h000;

    cur_tag = "R8";
    do_start(); send_byte(8'hF4); do_start(); send_byte(8'hA5);
    check_out(1'b0, 1'b0, "R8");
    mode_10b = 1'b0;
    @(negedge clk); start_det = 1'b1; byte_vld = 1'b1; byte_data = 8'h4A;
    @(negedge clk); start_det = 1'b0; byte_vld = 1'b0;
    check_out(1'b0, 1'b0, "R8");
    send_byte(8'h4A); check_out(1'b1, 1'b0, "R8");

    cur_tag = "R9";
    slave_inhibit = 1'b1; gc_en = 1'b1;
    do_start(); send_byte(8'h4A); check_out(1'b0, 1'b0, "R9");
    do_start(); send_byte(8'h00); check_out(1'b0, 1'b0, "R9");
    slave_inhibit = 1'b0; mode_10b = 1'b1;
    do_start(); send_byte(8'hF4); slave_inhibit = 1'b1;
    send_byte(8'hA5); check_out(1'b0, 1'b0, "R9");
    slave_inhibit = 1'b0;
    do_start(); send_byte(8'hF4); send_byte(8'hA5); check_out(1'b1, 1'b0, "R9");

    idle(3);
    done = 1'b1;
    report();
  end
endmodule